// File: doc/BRIEF.md
# GHASH Subkey Twist and Square Precompute

This block prepares the key material that a Karatsuba-style GHASH multiplier consumes. It accepts the 128-bit hash subkey (the block cipher's encryption of an all-zero block) on a single load strobe. It then produces three operand words.

The first word is a twisted form of the subkey, which folds the bit reflection of GHASH into a one-bit shift and a conditional XOR. The second is the square of that twisted value, reduced in the same domain. The third packs the XOR of the two 64-bit halves of each of the first two words, which is the middle operand a three-product multiplier needs.

Work starts on a load strobe and is reported through busy and done signals. The three results appear together on the done cycle. Downstream logic reads them in slot order: twisted key as slot 0, packed middle word as slot 1, square as slot 2. One iterative 64-bit carry-less multiplier, retiring one bit per cycle, forms all three partial products of the square in turn.

Top module: `ghk_precompute`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0 and twist_o, packed_o and hsq_o are all zero.
- R2: With A = {h_i[63:0], h_i[127:64]} (halves swapped), twist_o equals A shifted left by one bit within 128 bits. When A[127] is 1, that value is also XORed with {64'hC200000000000000, 64'h0000000000000001}.
- R3: hsq_o is the reduced carry-less square of twist_o. Let the 256-bit square be split into 64-bit words w3..w0, most significant first, and let K = 64'hC200000000000000. Form m1 = w0·K (128-bit carry-less). Form v = {w0 ^ m1[127:64], w1 ^ m1[63:0]}. Form m2 = v[63:0]·K. Then hsq_o = m2 ^ {v[63:0], v[127:64]} ^ {w3, w2}.
- R4: packed_o[63:0] equals twist_o[127:64] ^ twist_o[63:0], and packed_o[127:64] equals hsq_o[127:64] ^ hsq_o[63:0].
- R5: A load_i sampled while busy_o is 0 raises busy_o on the next cycle. Completion is a one-cycle done_o pulse, on which busy_o is already 0.
- R6: A load_i sampled while busy_o is 1 is ignored: the running job finishes with the results of the first key and no second job follows.
- R7: twist_o, packed_o and hsq_o change only on a done_o cycle; changes on h_i without a load leave them unchanged.
- R8: done_o is asserted no more than 210 cycles after the accepted load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start strobe, samples h_i |
| h_i | input | 128 | Hash subkey |
| busy_o | output | 1 | Precompute in progress |
| done_o | output | 1 | One-cycle completion pulse |
| twist_o | output | 128 | Slot 0: twisted subkey |
| packed_o | output | 128 | Slot 1: packed Karatsuba middle operands |
| hsq_o | output | 128 | Slot 2: twisted subkey squared |

## Verification
The hardest situation to reach from the ports is a second load arriving partway through a job. It must be dropped without corrupting the operand register that the later partial products still read. The bench starts a job, waits part of the way into the first multiplication, then pulses load with a different key. It checks that all three outputs match the first key and that busy stays low long after done. The conditional fold in the twist is reached by keys whose swapped top bit is set, chosen so the constant appears alone in the result.

// File: rtl/ghk_pkg.sv
// Shared constants and types for the GHASH subkey precompute.
// Assumes 64-bit lanes; the reduction constant is derived, not typed in.
package ghk_pkg;
    localparam int          LANE_W   = 64;
    localparam logic [7:0]  RED_BYTE = 8'hE1;
    // 0xE1 moved up 57 places leaves 0xC2 in the top byte of a lane
    localparam logic [LANE_W-1:0] RED_K = {{(LANE_W-8){1'b0}}, RED_BYTE} << 57;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_HH,
        ST_MM,
        ST_FIN
    } ghk_state_e;
endpackage

// File: rtl/ghk_twist.sv
// Converts a subkey into its twisted form: swap lanes, shift left one bit,
// fold the lost top bit back with the reduction constant.
// Assumes W is two lanes of the package lane width. Purely combinational.
module ghk_twist #(
    parameter int W = 128
) (
    input  logic [W-1:0] key_i,
    output logic [W-1:0] twist_o
);
    localparam int HW = W / 2;

    logic [W-1:0] swapped;
    logic [W-1:0] fold;

    // Swap halves, shift, and apply the conditional fold constant
    always_comb begin
        swapped = {key_i[HW-1:0], key_i[W-1:HW]};
        fold    = {ghk_pkg::RED_K, {(HW-1){1'b0}}, 1'b1};
        twist_o = {swapped[W-2:0], 1'b0} ^ (swapped[W-1] ? fold : '0);
    end
endmodule

// File: rtl/ghk_clmul_iter.sv
// Iterative carry-less multiplier, one multiplier bit per cycle.
// start_i loads operands; done_o pulses once when prod_o is final.
// Assumes start_i is only raised when no product is in progress.
module ghk_clmul_iter #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           done_o,
    output logic [2*W-1:0] prod_o
);
    localparam int CW = $clog2(W);

    logic [2*W-1:0] mcand_q;
    logic [2*W-1:0] acc_q;
    logic [W-1:0]   mplier_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic           done_q;

    // Shift-and-XOR datapath with bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            acc_q    <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                mcand_q  <= {{W{1'b0}}, a_i};
                mplier_q <= b_i;
                acc_q    <= '0;
                cnt_q    <= '0;
                run_q    <= 1'b1;
            end else if (run_q) begin
                acc_q    <= acc_q ^ (mplier_q[0] ? mcand_q : '0);
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign prod_o = acc_q;
endmodule

// File: rtl/ghk_reduce.sv
// Two-phase reduction of a 256-bit carry-less product in the twisted domain.
// Multiplications by the sparse constant are shift-XOR trees. Combinational.
module ghk_reduce #(
    parameter int H = 64
) (
    input  logic [4*H-1:0] wide_i,
    output logic [2*H-1:0] rem_o
);
    logic [H-1:0]   w0, w1, w2, w3;
    logic [2*H-1:0] m1, m2, v;

    // Carry-less product of a lane with the reduction constant
    function automatic logic [2*H-1:0] mul_k(input logic [H-1:0] x);
        logic [2*H-1:0] r;
        r = '0;
        for (int i = 0; i < H; i++) begin
            if (ghk_pkg::RED_K[i]) r = r ^ ({{H{1'b0}}, x} << i);
        end
        return r;
    endfunction

    // Fold the low two words into the high two words
    always_comb begin
        {w3, w2, w1, w0} = wide_i;
        m1    = mul_k(w0);
        v     = {w0 ^ m1[2*H-1:H], w1 ^ m1[H-1:0]};
        m2    = mul_k(v[H-1:0]);
        rem_o = m2 ^ {v[H-1:0], v[2*H-1:H]} ^ {w3, w2};
    end
endmodule

// File: rtl/ghk_precompute.sv
// Top of the subkey precompute: twist on load, three squared partial
// products through one iterative multiplier, Karatsuba recombination,
// reduction, and registered outputs published on a one-cycle done pulse.
// Assumes load_i is a strobe; loads during a job are dropped.
module ghk_precompute #(
    parameter int LANE_W = ghk_pkg::LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [2*LANE_W-1:0] h_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2*LANE_W-1:0] twist_o,
    output logic [2*LANE_W-1:0] packed_o,
    output logic [2*LANE_W-1:0] hsq_o
);
    import ghk_pkg::*;

    localparam int BW = 2 * LANE_W;

    ghk_state_e        state_q;
    logic [BW-1:0]     tw_q, xl_q, xh_q, xm_q;
    logic [BW-1:0]     twist_d, mul_prod, mid, rem;
    logic [2*BW-1:0]   wide;
    logic [LANE_W-1:0] op;
    logic              start_q, mul_done, done_q;
    logic [BW-1:0]     twist_q, packed_q, hsq_q;

    ghk_twist #(.W(BW)) u_twist (
        .key_i   (h_i),
        .twist_o (twist_d)
    );

    // Operand for the current squared partial product
    always_comb begin
        case (state_q)
            ST_HH:   op = tw_q[BW-1:LANE_W];
            ST_MM:   op = tw_q[BW-1:LANE_W] ^ tw_q[LANE_W-1:0];
            default: op = tw_q[LANE_W-1:0];
        endcase
    end

    ghk_clmul_iter #(.W(LANE_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_q),
        .a_i     (op),
        .b_i     (op),
        .done_o  (mul_done),
        .prod_o  (mul_prod)
    );

    // Karatsuba recombination into a 256-bit product
    always_comb begin
        mid  = xm_q ^ xl_q ^ xh_q;
        wide = {xh_q[BW-1:LANE_W],
                xh_q[LANE_W-1:0] ^ mid[BW-1:LANE_W],
                xl_q[BW-1:LANE_W] ^ mid[LANE_W-1:0],
                xl_q[LANE_W-1:0]};
    end

    ghk_reduce #(.H(LANE_W)) u_red (
        .wide_i (wide),
        .rem_o  (rem)
    );

    // Sequencer: accept load, run three products, publish results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tw_q     <= '0;
            xl_q     <= '0;
            xh_q     <= '0;
            xm_q     <= '0;
            start_q  <= 1'b0;
            done_q   <= 1'b0;
            twist_q  <= '0;
            packed_q <= '0;
            hsq_q    <= '0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                ST_IDLE: if (load_i) begin
                    tw_q    <= twist_d;
                    start_q <= 1'b1;
                    state_q <= ST_LL;
                end
                ST_LL: if (mul_done) begin
                    xl_q    <= mul_prod;
                    start_q <= 1'b1;
                    state_q <= ST_HH;
                end
                ST_HH: if (mul_done) begin
                    xh_q    <= mul_prod;
                    start_q <= 1'b1;
                    state_q <= ST_MM;
                end
                ST_MM: if (mul_done) begin
                    xm_q    <= mul_prod;
                    state_q <= ST_FIN;
                end
                default: begin
                    twist_q  <= tw_q;
                    hsq_q    <= rem;
                    packed_q <= {rem[BW-1:LANE_W] ^ rem[LANE_W-1:0],
                                 tw_q[BW-1:LANE_W] ^ tw_q[LANE_W-1:0]};
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign twist_o  = twist_q;
    assign packed_o = packed_q;
    assign hsq_o    = hsq_q;
endmodule

// File: rtl/ghk_precompute_chk.sv
// Port-level checker for the subkey precompute, bound to every instance.
// Assumes the latency bound of the requirements (210 cycles).
module ghk_precompute_chk #(
    parameter int BW    = 128,
    parameter int LIMIT = 210
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [BW-1:0] twist_o,
    input logic [BW-1:0] packed_o,
    input logic [BW-1:0] hsq_o
);
    logic [15:0] busy_cnt_q;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt_q <= '0;
        else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
        else             busy_cnt_q <= '0;
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=> busy_o);

    p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(load_i));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(twist_o) && $stable(packed_o) && $stable(hsq_o)));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt_q <= 16'(LIMIT));
endmodule

bind ghk_precompute ghk_precompute_chk #(.BW(2 * LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .twist_o  (twist_o),
    .packed_o (packed_o),
    .hsq_o    (hsq_o)
);

// File: tb/ghk_precompute_test.sv
module ghk_precompute_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [127:0] h_i = '0;
    logic         busy_o, done_o;
    logic [127:0] twist_o, packed_o, hsq_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ghk_precompute uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .h_i      (h_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .twist_o  (twist_o),
        .packed_o (packed_o),
        .hsq_o    (hsq_o)
    );

    localparam int NV = 5;
    localparam logic [127:0] VEC_H [NV] = '{
        128'h0,
        128'h0000_0000_0000_0000_0000_0000_0000_0001,
        128'h0000_0000_0000_0001_0000_0000_0000_0000,
        128'h0000_0000_0000_0000_8000_0000_0000_0000,
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
    };
    localparam logic [127:0] VEC_T [NV] = '{
        128'h0,
        128'h0000_0000_0000_0002_0000_0000_0000_0000,
        128'h0000_0000_0000_0000_0000_0000_0000_0002,
        128'hC200_0000_0000_0000_0000_0000_0000_0001,
        128'h3FB9_7530_ECA8_6420_0246_8ACF_1357_9BDF
    };

    // Reference model from the requirement text
    function automatic logic [127:0] ref_twist(input logic [127:0] h);
        logic [127:0] a;
        a = {h[63:0], h[127:64]};
        return (a << 1) ^ (a[127] ? {64'hC200000000000000, 64'h1} : 128'h0);
    endfunction

    function automatic logic [255:0] sq256(input logic [127:0] x);
        logic [255:0] p;
        p = '0;
        for (int i = 0; i < 128; i++)
            if (x[i]) p = p ^ ({128'h0, x} << i);
        return p;
    endfunction

    function automatic logic [127:0] by_k(input logic [63:0] x);
        logic [127:0] r;
        r = ({64'h0, x} << 63) ^ ({64'h0, x} << 62) ^ ({64'h0, x} << 57);
        return r;
    endfunction

    function automatic logic [127:0] ref_sq(input logic [127:0] h);
        logic [255:0] p;
        logic [127:0] m1, v, m2;
        p  = sq256(ref_twist(h));
        m1 = by_k(p[63:0]);
        v  = {p[63:0] ^ m1[127:64], p[127:64] ^ m1[63:0]};
        m2 = by_k(v[63:0]);
        return m2 ^ {v[63:0], v[127:64]} ^ p[255:128];
    endfunction

    function automatic logic [127:0] ref_packed(input logic [127:0] h);
        logic [127:0] t, s;
        t = ref_twist(h);
        s = ref_sq(h);
        return {s[127:64] ^ s[63:0], t[127:64] ^ t[63:0]};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_job(input logic [127:0] h);
        @(negedge clk);
        h_i    = h;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Counts negedges after the load negedge until done_o is seen
    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [127:0] keep_t, keep_p, keep_s;

        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 busy in reset", {127'h0, busy_o}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {127'h0, done_o}, 128'h0);
        check("R1 twist reset", twist_o, 128'h0);
        check("R1 packed reset", packed_o, 128'h0);
        check("R1 hsq reset", hsq_o, 128'h0);

        // Vector table: R2 twist, R3 square, R4 packing, R8 latency
        for (int k = 0; k < NV; k++) begin
            start_job(VEC_H[k]);
            check("R5 busy after load", {127'h0, busy_o}, 128'h1);
            wait_done(cyc);
            check("R8 latency bound", {127'h0, (cyc <= 210)}, 128'h1);
            check("R5 busy low at done", {127'h0, busy_o}, 128'h0);
            check("R2 twist", twist_o, VEC_T[k]);
            check("R3 square", hsq_o, ref_sq(VEC_H[k]));
            check("R4 packed", packed_o, ref_packed(VEC_H[k]));
            @(negedge clk);
            check("R5 done single cycle", {127'h0, done_o}, 128'h0);
        end

        // R3 and R4 hand-worked anchor: key 1 squares to 4, packs to {4,2}
        start_job(128'h1);
        wait_done(cyc);
        check("R3 anchor square", hsq_o, 128'h4);
        check("R4 anchor packed", packed_o, {64'h4, 64'h2});

        // R6: second load mid-job is dropped
        @(negedge clk);
        h_i    = VEC_H[4];
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        repeat (20) @(negedge clk);
        h_i    = VEC_H[3];
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        h_i    = '0;
        wait_done(cyc);
        check("R6 twist of first key", twist_o, VEC_T[4]);
        check("R6 square of first key", hsq_o, ref_sq(VEC_H[4]));
        repeat (250) begin
            @(negedge clk);
            if (busy_o || done_o) break;
        end
        check("R6 no second job", {126'h0, busy_o, done_o}, 128'h0);

        // R7: outputs hold while h_i moves without a load
        keep_t = twist_o;
        keep_p = packed_o;
        keep_s = hsq_o;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            h_i = {4{32'hA5A5_0000 + 32'(j)}};
        end
        repeat (5) @(negedge clk);
        check("R7 twist held", twist_o, keep_t);
        check("R7 packed held", packed_o, keep_p);
        check("R7 square held", hsq_o, keep_s);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule